// File: doc/BRIEF.md
# Product Term Array and Allocator

This block is one logic block of a small programmable-logic fabric. It receives 36 routed signals, presents each one to a programmable AND plane in both its true and complemented form, and forms a pool of 86 product terms. A steering stage then ORs a chosen subset of that pool into one sum-of-products result for each of 16 macrocells. Any macrocell can take between zero and sixteen terms, and a single term can feed several macrocells at the same time.

The data path from `in_sig` to `mac_sum` is purely combinational. It has no register and no handshake. A sum changes whenever an input or the stored configuration changes, so the stream rules of valid/ready do not apply. Only the configuration is clocked. A single write port, made of `cfg_we`, `cfg_addr` and `cfg_data`, loads one row per clock: a column-mask row for a product term, or a steering row for a macrocell. This is done before operation.

Top module: `pt_logic_block`

## Requirements
- R1: After reset every product term is disabled with an empty column mask, every steering row is empty, `mac_sum` is all zeros and `cfg_err` is 0.
- R2: Column 2i of a term mask selects input i true, and column 2i+1 selects input i complemented. An enabled term is the AND of its selected columns, evaluated combinationally from `in_sig`.
- R3: An enabled term with an empty column mask evaluates to 1.
- R4: A term whose disable bit is set contributes 0 to every sum, whatever its mask. The disable bit is `cfg_data[72]` in a term write.
- R5: A macrocell with an empty steering row outputs 0.
- R6: `mac_sum[m]` is the OR of the terms whose bits are set in steering row m (bit t selects term t). A row with exactly 16 bits set is accepted.
- R7: A term steered to several macrocells drives all of them at the same time.
- R8: A steering write with more than 16 bits set in `cfg_data[85:0]` is rejected. The row keeps its old value, and `cfg_err` reads 1 after that clock edge.
- R9: Address map: addresses 0..85 write term t (mask in `cfg_data[71:0]`, disable in bit 72), and addresses 86..101 write steering row m = address-86. An accepted write takes effect at the next rising edge and clears `cfg_err`.
- R10: A write to an address above 101 changes neither the configuration nor `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset of configuration |
| in_sig | input | 36 | Routed input signals to the AND plane |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 7 | Row select: term row or steering row |
| cfg_data | input | 86 | Row contents |
| cfg_err | output | 1 | Last effective write was rejected (over 16 terms) |
| mac_sum | output | 16 | Sum-of-products result per macrocell |

## Verification
Each sum is due in the same cycle as the input change that causes it. The bench therefore sets `in_sig` on a falling edge and reads `mac_sum` 1 ns later, before any clock edge can intervene. Configuration writes and `cfg_err` become visible one rising edge after the write is presented. Write stimulus is applied on a falling edge and removed on the next one, and the results are sampled at that second falling edge. One check reads the sum between presenting a write and the edge that commits it, which confirms that the old setting still holds.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    ROW_TERM = 2'd0,
    ROW_MAC  = 2'd1,
    ROW_NONE = 2'd2
  } row_kind_e;
endpackage

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
  parameter int NCOL  = 72,
  parameter int NPT   = 86,
  parameter int NMC   = 16,
  parameter int MAXPT = 16,
  parameter int DW    = 86,
  parameter int AW    = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 data,
  output logic [NPT-1:0][NCOL-1:0]      col_mask,
  output logic [NPT-1:0]                term_off,
  output logic [NMC-1:0][NPT-1:0]       steer,
  output logic                          err
);
  import pt_pkg::*;

  localparam int CW = $clog2(NPT + 1);
  localparam logic [AW-1:0] MAC_BASE = AW'(NPT);
  localparam logic [AW-1:0] MAC_END  = AW'(NPT + NMC);

  row_kind_e     kind;
  logic [CW-1:0] sel_cnt;
  logic          too_many;

  always_comb begin
    if (addr < MAC_BASE)     kind = ROW_TERM;
    else if (addr < MAC_END) kind = ROW_MAC;
    else                     kind = ROW_NONE;
  end

  // population count of the requested steering row
  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NPT; i++) sel_cnt = sel_cnt + CW'(data[i]);
  end
  assign too_many = sel_cnt > CW'(MAXPT);

  genvar t, m;
  generate
    for (t = 0; t < NPT; t++) begin : g_term_row
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          col_mask[t] <= '0;
          term_off[t] <= 1'b1;
        end else if (we && kind == ROW_TERM && addr == AW'(t)) begin
          col_mask[t] <= data[NCOL-1:0];
          term_off[t] <= data[NCOL];
        end
      end
    end
    for (m = 0; m < NMC; m++) begin : g_mac_row
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          steer[m] <= '0;
        end else if (we && kind == ROW_MAC && !too_many && addr == AW'(NPT + m)) begin
          steer[m] <= data[NPT-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (we) begin
      case (kind)
        ROW_TERM: err <= 1'b0;
        ROW_MAC:  err <= too_many;
        default:  err <= err;
      endcase
    end
  end
endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane #(
  parameter int NIN = 36,
  parameter int NPT = 86,
  localparam int NCOL = 2 * NIN
) (
  input  logic [NIN-1:0]             in_sig,
  input  logic [NPT-1:0][NCOL-1:0]   col_mask,
  input  logic [NPT-1:0]             term_off,
  output logic [NPT-1:0]             term_vec
);
  logic [NCOL-1:0] cols;

  genvar i, t;
  generate
    for (i = 0; i < NIN; i++) begin : g_col
      assign cols[2*i]   = in_sig[i];
      assign cols[2*i+1] = ~in_sig[i];
    end
    for (t = 0; t < NPT; t++) begin : g_term
      // unselected columns are forced to 1 so they do not gate the AND
      assign term_vec[t] = ~term_off[t] & (&(cols | ~col_mask[t]));
    end
  endgenerate
endmodule

// File: rtl/pt_allocator.sv
module pt_allocator #(
  parameter int NPT = 86,
  parameter int NMC = 16
) (
  input  logic [NPT-1:0]             term_vec,
  input  logic [NMC-1:0][NPT-1:0]    steer,
  output logic [NMC-1:0]             mac_sum
);
  genvar m;
  generate
    for (m = 0; m < NMC; m++) begin : g_sum
      assign mac_sum[m] = |(steer[m] & term_vec);
    end
  endgenerate
endmodule

// File: rtl/pt_logic_block.sv
module pt_logic_block #(
  parameter int NIN   = 36,
  parameter int NPT   = 86,
  parameter int NMC   = 16,
  parameter int MAXPT = 16,
  localparam int NCOL = 2 * NIN,
  localparam int DW   = (NCOL + 1 > NPT) ? NCOL + 1 : NPT,
  localparam int AW   = $clog2(NPT + NMC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIN-1:0]  in_sig,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_data,
  output logic            cfg_err,
  output logic [NMC-1:0]  mac_sum
);
  logic [NPT-1:0][NCOL-1:0] col_mask;
  logic [NPT-1:0]           term_off;
  logic [NMC-1:0][NPT-1:0]  steer;
  logic [NPT-1:0]           term_vec;

  pt_cfg_store #(
    .NCOL(NCOL), .NPT(NPT), .NMC(NMC), .MAXPT(MAXPT), .DW(DW), .AW(AW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
    .col_mask(col_mask), .term_off(term_off), .steer(steer), .err(cfg_err)
  );

  pt_and_plane #(.NIN(NIN), .NPT(NPT)) u_plane (
    .in_sig(in_sig), .col_mask(col_mask), .term_off(term_off), .term_vec(term_vec)
  );

  pt_allocator #(.NPT(NPT), .NMC(NMC)) u_alloc (
    .term_vec(term_vec), .steer(steer), .mac_sum(mac_sum)
  );
endmodule

// File: rtl/pt_logic_block_chk.sv
module pt_logic_block_chk #(
  parameter int NPT   = 86,
  parameter int NMC   = 16,
  parameter int MAXPT = 16,
  parameter int DW    = 86,
  parameter int AW    = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [AW-1:0]             cfg_addr,
  input logic [DW-1:0]             cfg_data,
  input logic                      cfg_err,
  input logic [NMC-1:0]            mac_sum,
  input logic [NPT-1:0]            term_vec,
  input logic [NPT-1:0]            term_off,
  input logic [NMC-1:0][NPT-1:0]   steer
);
  localparam logic [AW-1:0] MAC_BASE = AW'(NPT);
  localparam logic [AW-1:0] MAC_END  = AW'(NPT + NMC);

  logic mac_wr, over_wr, ok_wr, bad_wr;
  assign mac_wr  = cfg_we && cfg_addr >= MAC_BASE && cfg_addr < MAC_END;
  assign over_wr = mac_wr && ($countones(cfg_data[NPT-1:0]) > MAXPT);
  assign ok_wr   = cfg_we && cfg_addr < MAC_END && !over_wr;
  assign bad_wr  = cfg_we && cfg_addr >= MAC_END;

  // R8
  over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_wr |=> cfg_err);
  // R8
  over_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_wr |=> $stable(steer));
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_we));
  // R9
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_wr |=> !cfg_err);
  // R10
  bad_addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ($stable(cfg_err) && $stable(steer) && $stable(term_off)));
  // R4
  off_term_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_vec & term_off) == '0);

  genvar m;
  generate
    for (m = 0; m < NMC; m++) begin : g_mac_chk
      // R6
      steer_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(steer[m]) <= MAXPT);
      // R5
      empty_mac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steer[m] == '0) |-> !mac_sum[m]);
    end
  endgenerate
endmodule

bind pt_logic_block pt_logic_block_chk #(
  .NPT(NPT), .NMC(NMC), .MAXPT(MAXPT), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_data(cfg_data), .cfg_err(cfg_err), .mac_sum(mac_sum),
  .term_vec(term_vec), .term_off(term_off), .steer(steer)
);

// File: tb/tb_pt_logic_block.sv
`timescale 1ns/1ps
module tb_pt_logic_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] in_sig = '0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [85:0] cfg_data = '0;
  logic        cfg_err;
  logic [15:0] mac_sum;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pt_logic_block dut (
    .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_err(cfg_err), .mac_sum(mac_sum)
  );

  typedef struct packed {
    logic [35:0] stim;
    logic [15:0] exp;
  } vec_t;

  // mac0=a&b, mac1=~a|b, mac2=1, mac3=(c&~d)|(a&b), mac6=in35, others 0
  localparam vec_t VECS [9] = '{
    '{36'h0_0000_0000, 16'h0006},
    '{36'h0_0000_0001, 16'h0004},
    '{36'h0_0000_0003, 16'h000F},
    '{36'h0_0000_0002, 16'h0006},
    '{36'h0_0000_0004, 16'h000E},
    '{36'h0_0000_000C, 16'h0006},
    '{36'h8_0000_0000, 16'h0046},
    '{36'hF_FFFF_FFFF, 16'h004F},
    '{36'h8_0000_0005, 16'h004C}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [85:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    in_sig = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sums after reset", mac_sum, 16'h0000);
    check("R1 err after reset", {15'b0, cfg_err}, 16'h0000);

    // terms: 0=in0&in1, 1=~in0, 2=empty, 3=in2&~in3, 85=in35; 4 stays disabled
    wr(7'd0,  86'h5);
    wr(7'd1,  86'h2);
    wr(7'd2,  86'h0);
    wr(7'd3,  86'h90);
    wr(7'd85, 86'h1 << 70);

    // R9: steering for mac0 holds off until the edge
    @(negedge clk);
    in_sig = 36'h3;
    cfg_we = 1'b1; cfg_addr = 7'd86; cfg_data = 86'h1;
    #1;
    check("R9 before edge", {15'b0, mac_sum[0]}, 16'h0000);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 after edge", {15'b0, mac_sum[0]}, 16'h0001);

    wr(7'd87, 86'h3);
    wr(7'd88, 86'h4);
    wr(7'd89, 86'h9);       // R7 term0 shared with mac0/mac1
    wr(7'd90, 86'h10);      // disabled term4
    wr(7'd92, 86'hFFFF << 70);
    check("R6 sixteen accepted", {15'b0, cfg_err}, 16'h0000);

    // R8: seventeen terms rejected
    in_sig = '1;
    wr(7'd93, 86'h1FFFF << 69);
    check("R8 err raised", {15'b0, cfg_err}, 16'h0001);
    check("R8 row unchanged", {15'b0, mac_sum[7]}, 16'h0000);

    wr(7'd91, 86'h0);
    check("R9 err cleared", {15'b0, cfg_err}, 16'h0000);

    // R10: out-of-range write ignored
    wr(7'd120, '1);
    check("R10 err kept", {15'b0, cfg_err}, 16'h0000);
    check("R10 sums kept", mac_sum, 16'h004F);

    // R2 R3 R5 R6 R7 over the vector table
    foreach (VECS[k]) begin
      @(negedge clk);
      in_sig = VECS[k].stim;
      #1;
      check("R2 R3 R5 R6 R7 vector", mac_sum, VECS[k].exp);
    end

    // R4: enabling then disabling term4
    in_sig = '0;
    wr(7'd4, 86'h0);
    check("R4 term4 enabled", mac_sum, 16'h0016);
    wr(7'd4, 86'h1 << 72);
    check("R4 term4 disabled", mac_sum, 16'h0006);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule